// File: doc/BRIEF.md
# Serial Divider Programming Loader

This block receives divider settings for a frequency synthesizer over a three-wire serial link: a data line, a bit clock and a load strobe. All three lines are sampled by the system clock through a two-stage synchronizer. Each rising edge of the bit clock shifts one data bit into a 19-bit shift register, most significant bit first. The last bit shifted in is a steering bit.

A rising edge on the load line copies the shift register into one of two holding registers, chosen by the steering bit. The reference register holds a 14-bit reference divide value and a prescaler-ratio select bit. The program register holds a 7-bit swallow count and an 11-bit main divide count. A one-cycle strobe marks each holding register that was updated, so the counters downstream can reload.

Top module: `synth_prog_loader`

## Requirements
- R1: After reset, all divide fields are zero, the prescaler select is 0 (the 64/65 ratio), and both strobes are low.
- R2: Each rising edge of `ser_clk_i` shifts `ser_data_i` into shift-register bit 0, and the older bits move up by one. A held-high or falling bit clock shifts nothing.
- R3: On a load edge with shift bit 0 = 1, `ref_div_o` takes shift bits 14..1 (bit 1 is the LSB) and `pre_sel_o` takes shift bit 15 (1 selects 32/33, 0 selects 64/65). The program fields are left unchanged.
- R4: On a load edge with shift bit 0 = 0, `swal_o` takes shift bits 7..1 (bit 1 is the LSB) and `main_div_o` takes shift bits 18..8 (bit 18 is the MSB). The reference fields are left unchanged.
- R5: Each accepted load raises exactly one strobe for exactly one system clock: `ref_stb_o` for a reference load, `prog_stb_o` for a program load. The strobe rises in the same cycle as the new field values.
- R6: A reference load whose divide value is below 3 is ignored. The reference fields keep their values and no strobe is raised.
- R7: A program load whose main divide value is below 3 is ignored. The program fields keep their values and no strobe is raised.
- R8: A load line that stays high causes no further load. A bit clock left high across a load corrupts nothing. A second load edge with no new bits reloads the same word and strobes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_data_i | input | 1 | Serial data line |
| ser_clk_i | input | 1 | Serial bit clock (asynchronous to the system clock) |
| ser_le_i | input | 1 | Load line; a rising edge transfers the word |
| ref_div_o | output | 14 | Latched reference divide value |
| pre_sel_o | output | 1 | Prescaler ratio select (1 = 32/33, 0 = 64/65) |
| swal_o | output | 7 | Latched swallow count |
| main_div_o | output | 11 | Latched main divide value |
| ref_stb_o | output | 1 | One-cycle pulse on a reference update |
| prog_stb_o | output | 1 | One-cycle pulse on a program update |

## Verification
A shift register that drops or duplicates a bit shows up on the very next load. The latched fields then appear rotated or shifted by one position, and the steering bit can send the word to the wrong holding register, which changes the other register's fields. A wrong edge detector shows within four system clocks of a load edge, either as a missing or doubled strobe or as an extra load while the line is held high. The range filter is exposed by words with a divide value of 0 to 2, which must leave every output unchanged and raise no strobe.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int SR_W     = 19;
  localparam int REF_W    = 14;
  localparam int SWAL_W   = 7;
  localparam int MAIN_W   = 11;
  localparam int MIN_DIV  = 3;
  localparam int REF_LSB  = 1;
  localparam int PRE_BIT  = REF_LSB + REF_W;
  localparam int SWAL_LSB = 1;
  localparam int MAIN_LSB = SWAL_LSB + SWAL_W;

  typedef enum logic {SEL_PROG = 1'b0, SEL_REF = 1'b1} ctl_sel_e;

  typedef struct packed {
    logic             pre;
    logic [REF_W-1:0] div;
  } ref_word_t;

  typedef struct packed {
    logic [MAIN_W-1:0] main_div;
    logic [SWAL_W-1:0] swal;
  } prog_word_t;
endpackage

// File: rtl/spl_pin_sync.sv
module spl_pin_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0][N-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], pin_i};
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  for (genvar i = 0; i < N; i++) begin : g_chk
    p_rise_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[i] |=> !rise_o[i]);
  end
endmodule

// File: rtl/spl_shift_reg.sv
module spl_shift_reg
  import synth_prog_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_en_i,
  input  logic            bit_i,
  output logic [SR_W-1:0] word_o
);
  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sr_q <= '0;
    else if (shift_en_i) sr_q <= {sr_q[SR_W-2:0], bit_i};
  end

  assign word_o = sr_q;

  p_hold_no_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(word_o));
  p_shift_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> word_o[SR_W-1:1] == $past(word_o[SR_W-2:0]));
endmodule

// File: rtl/spl_latch_bank.sv
module spl_latch_bank
  import synth_prog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SR_W-1:0]   word_i,
  output logic [REF_W-1:0]  ref_div_o,
  output logic              pre_sel_o,
  output logic [SWAL_W-1:0] swal_o,
  output logic [MAIN_W-1:0] main_div_o,
  output logic              ref_stb_o,
  output logic              prog_stb_o
);
  ctl_sel_e   sel;
  ref_word_t  ref_d, ref_q;
  prog_word_t prog_d, prog_q;
  logic       ref_ok, prog_ok;
  logic       ref_stb_q, prog_stb_q;

  always_comb begin
    sel             = ctl_sel_e'(word_i[0]);
    ref_d.div       = word_i[PRE_BIT-1:REF_LSB];
    ref_d.pre       = word_i[PRE_BIT];
    prog_d.swal     = word_i[MAIN_LSB-1:SWAL_LSB];
    prog_d.main_div = word_i[SR_W-1:MAIN_LSB];
    ref_ok  = load_i && (sel == SEL_REF)  && (ref_d.div       >= REF_W'(MIN_DIV));
    prog_ok = load_i && (sel == SEL_PROG) && (prog_d.main_div >= MAIN_W'(MIN_DIV));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q      <= '0;
      prog_q     <= '0;
      ref_stb_q  <= 1'b0;
      prog_stb_q <= 1'b0;
    end else begin
      if (ref_ok)  ref_q  <= ref_d;
      if (prog_ok) prog_q <= prog_d;
      ref_stb_q  <= ref_ok;
      prog_stb_q <= prog_ok;
    end
  end

  assign ref_div_o  = ref_q.div;
  assign pre_sel_o  = ref_q.pre;
  assign swal_o     = prog_q.swal;
  assign main_div_o = prog_q.main_div;
  assign ref_stb_o  = ref_stb_q;
  assign prog_stb_o = prog_stb_q;

  p_stb_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ref_stb_o && prog_stb_o));
  p_ref_min_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_stb_o |-> ref_div_o >= REF_W'(MIN_DIV));
  p_main_min_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_stb_o |-> main_div_o >= MAIN_W'(MIN_DIV));
  p_ref_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_stb_o |-> $stable(ref_div_o) && $stable(pre_sel_o));
  p_prog_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_stb_o |-> $stable(swal_o) && $stable(main_div_o));
endmodule

// File: rtl/synth_prog_loader.sv
module synth_prog_loader
  import synth_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_data_i,
  input  logic              ser_clk_i,
  input  logic              ser_le_i,
  output logic [REF_W-1:0]  ref_div_o,
  output logic              pre_sel_o,
  output logic [SWAL_W-1:0] swal_o,
  output logic [MAIN_W-1:0] main_div_o,
  output logic              ref_stb_o,
  output logic              prog_stb_o
);
  localparam int PIN_DAT = 0;
  localparam int PIN_CLK = 1;
  localparam int PIN_LE  = 2;

  logic [2:0]      lvl, rise;
  logic [SR_W-1:0] word;
  logic            unused_pins;

  spl_pin_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({ser_le_i, ser_clk_i, ser_data_i}),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  assign unused_pins = ^{rise[PIN_DAT], lvl[PIN_CLK], lvl[PIN_LE]};

  spl_shift_reg u_sr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (rise[PIN_CLK]),
    .bit_i      (lvl[PIN_DAT]),
    .word_o     (word)
  );

  spl_latch_bank u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (rise[PIN_LE]),
    .word_i     (word),
    .ref_div_o  (ref_div_o),
    .pre_sel_o  (pre_sel_o),
    .swal_o     (swal_o),
    .main_div_o (main_div_o),
    .ref_stb_o  (ref_stb_o),
    .prog_stb_o (prog_stb_o)
  );

  p_stb_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_stb_o || prog_stb_o) |=> !(ref_stb_o || prog_stb_o));
endmodule

// File: tb/synth_prog_loader_tb.sv
`timescale 1ns/1ps
module synth_prog_loader_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_le = 1'b0;
  logic [13:0] ref_div;
  logic        pre_sel;
  logic [6:0]  swal;
  logic [10:0] main_div;
  logic        ref_stb, prog_stb;

  int n_chk = 0, n_fail = 0;
  int ref_cnt = 0, prog_cnt = 0;
  logic [18:0] m_sr = '0;
  logic [13:0] m_ref = '0;
  logic        m_pre = 1'b0;
  logic [6:0]  m_swal = '0;
  logic [10:0] m_main = '0;

  always #5 clk = ~clk;

  synth_prog_loader u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ser_data_i(ser_data), .ser_clk_i(ser_clk),
    .ser_le_i(ser_le), .ref_div_o(ref_div), .pre_sel_o(pre_sel), .swal_o(swal),
    .main_div_o(main_div), .ref_stb_o(ref_stb), .prog_stb_o(prog_stb)
  );

  always @(negedge clk) begin
    if (ref_stb)  ref_cnt++;
    if (prog_stb) prog_cnt++;
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // shift nbits of w, MSB first; optionally leave bit clock high after last bit
  task automatic send(input logic [18:0] w, input int nbits, input bit keep_high);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_data = w[i];
      cyc(3);
      ser_clk = 1'b1;
      m_sr = {m_sr[17:0], w[i]};
      cyc(3);
      if (i != 0 || !keep_high) begin
        ser_clk = 1'b0;
        cyc(3);
      end
    end
  endtask

  function automatic string tag_of(input logic [18:0] s);
    if (s[0]) return (s[14:1] < 3) ? "R6" : "R3";
    return (s[18:8] < 3) ? "R7" : "R4";
  endfunction

  // pulse load line, update model, check all outputs and strobe counts
  task automatic load_and_check(input string req);
    int r0, p0, er, ep;
    r0 = ref_cnt; p0 = prog_cnt; er = 0; ep = 0;
    ser_le = 1'b1;
    cyc(6);
    ser_le = 1'b0;
    cyc(4);
    if (m_sr[0] && m_sr[14:1] >= 3) begin
      m_ref = m_sr[14:1]; m_pre = m_sr[15]; er = 1;
    end else if (!m_sr[0] && m_sr[18:8] >= 3) begin
      m_swal = m_sr[7:1]; m_main = m_sr[18:8]; ep = 1;
    end
    chk(req, "ref_div", int'(ref_div), int'(m_ref));
    chk(req, "pre_sel", int'(pre_sel), int'(m_pre));
    chk(req, "swal", int'(swal), int'(m_swal));
    chk(req, "main_div", int'(main_div), int'(m_main));
    chk({req, "/R5"}, "ref strobes", ref_cnt - r0, er);
    chk({req, "/R5"}, "prog strobes", prog_cnt - p0, ep);
  endtask

  function automatic logic [18:0] ref_word(input logic [13:0] r, input logic p);
    return {3'b000, p, r, 1'b1};
  endfunction

  function automatic logic [18:0] prog_word(input logic [10:0] b, input logic [6:0] a);
    return {b, a, 1'b0};
  endfunction

  initial begin
    int seed;
    seed = $urandom(32'd20251);
    cyc(3);
    chk("R1", "ref_div", int'(ref_div), 0);
    chk("R1", "strobes", int'(ref_stb) + int'(prog_stb), 0);
    rst_ni = 1'b1;
    cyc(3);
    chk("R1", "pre_sel", int'(pre_sel), 0);
    chk("R1", "swal", int'(swal), 0);
    chk("R1", "main_div", int'(main_div), 0);

    // directed corners
    send(prog_word(11'b101_0011_0110, 7'b010_1101), 19, 0); load_and_check("R2");
    send(ref_word(14'd3, 1'b0), 19, 0);        load_and_check("R3");
    send(ref_word(14'd2, 1'b1), 19, 0);        load_and_check("R6");
    send(ref_word(14'd0, 1'b1), 19, 0);        load_and_check("R6");
    send(ref_word(14'd16383, 1'b1), 19, 0);    load_and_check("R3");
    send(prog_word(11'd3, 7'd0), 19, 0);       load_and_check("R4");
    send(prog_word(11'd2, 7'd99), 19, 0);      load_and_check("R7");
    send(prog_word(11'd2047, 7'd127), 19, 0);  load_and_check("R4");
    send(ref_word(14'd1234, 1'b0), 16, 0);     load_and_check("R3");
    // bit clock left high across the load, then falling edge, then reload
    send(ref_word(14'd777, 1'b1), 19, 1);      load_and_check("R8");
    ser_clk = 1'b0; cyc(4);
    load_and_check("R8");
    // load line held high: only one load
    begin
      int r0;
      send(prog_word(11'd500, 7'd33), 19, 0);
      r0 = prog_cnt;
      ser_le = 1'b1; cyc(30);
      chk("R8", "strobes while held", prog_cnt - r0, 1);
      ser_le = 1'b0; cyc(4);
      m_swal = 7'd33; m_main = 11'd500;
      chk("R8", "main_div", int'(main_div), 500);
    end

    // constrained random
    for (int k = 0; k < 60; k++) begin
      logic [18:0] w;
      int nb;
      nb = 19;
      if ($urandom % 2) begin
        w = ref_word(($urandom % 6 == 0) ? 14'($urandom % 3) : 14'($urandom), 1'($urandom));
        if ($urandom % 3 == 0) nb = 16;
      end else begin
        w = prog_word(($urandom % 6 == 0) ? 11'($urandom % 3) : 11'($urandom), 7'($urandom));
      end
      send(w, nb, 0);
      load_and_check(tag_of(m_sr));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule